// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block keeps the two interrupt registers of a storage adapter: a status register whose bits are set by hardware events, and an enable (mask) register written by software. It raises the adapter interrupt whenever an enabled status bit is set. Completion events and message events each set their own status bit. Software acknowledges interrupts by writing ones to the status register, which clears those bits.

The interrupt leaves the block in one of two forms, chosen by `msg_mode`. In level mode a line follows the interrupt condition. In message mode the line stays low. Instead, a one-clock notification pulse is sent after each re-evaluation that finds the condition true. Every acknowledge write that occurs while completions are still waiting also produces a one-clock request to scan for completions again.

A two-state machine orders the re-evaluation. In `EV_IDLE` nothing is pending. Any event, status write or mask write moves it to `EV_EVAL` for the following cycle. In that cycle the condition is judged and a pulse may be emitted. The machine stays in `EV_EVAL` while updates keep arriving and returns to `EV_IDLE` after a cycle with no update. An adapter reset forces `EV_IDLE`.

Top module: `irq_unit`

## Requirements
- R1: `cmpl_evt` sets status bit 0 and `msg_evt` sets status bit 1. Each takes effect at the next clock edge.
- R2: A status write (`stat_wr`) clears exactly the status bits that are set in `stat_wdata`. All other status bits are left unchanged.
- R3: A mask write (`mask_wr`) replaces the whole mask register with `mask_wdata`.
- R4: With `msg_mode` low, `irq_level` equals the OR over all bits of (mask AND status), and `irq_pulse` stays low.
- R5: With `msg_mode` high, `irq_level` stays low. In the cycle after any event, status write or mask write, `irq_pulse` is high for exactly one clock if (mask AND status) is then nonzero.
- R6: A re-evaluation that finds (mask AND status) equal to zero produces no pulse.
- R7: `retry_req` is high for one clock in the cycle after a status write made while `cmpl_pending` is nonzero. It stays low after a status write made while `cmpl_pending` is zero.
- R8: `adapter_rst` clears the status register and leaves the mask register unchanged. After `rst_n` reset, all outputs are low.
- R9: An event that arrives in the same cycle as a status write clearing its bit leaves that bit set.
- R10: `irq_pulse` is never high while `msg_mode` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adapter_rst | input | 1 | Synchronous adapter reset; clears status only |
| cmpl_evt | input | 1 | Completion event, sets status bit 0 |
| msg_evt | input | 1 | Message event, sets status bit 1 |
| stat_wr | input | 1 | Status register write strobe (write-one-to-clear) |
| stat_wdata | input | REG_W | Bits to clear |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | REG_W | New mask value |
| msg_mode | input | 1 | 1 = notification pulses, 0 = level line |
| cmpl_pending | input | PEND_W | Count of completions still waiting |
| irq_level | output | 1 | Level interrupt line |
| irq_pulse | output | 1 | One-clock notification pulse |
| retry_req | output | 1 | One-clock request to rescan completions |

## Verification
Two functions can land in the same cycle: the setting of a status bit by an event, and the clearing of that bit by an acknowledge write. The bench drives `cmpl_evt` together with a status write of value 1 while the mask enables bit 0. It judges the result by checking that `irq_level` is high in the following cycle.

A second overlap is tested in message mode. A mask write and a status write each trigger a re-evaluation. The bench checks that a pulse follows only when the resulting mask and status still overlap.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
    localparam int BIT_CMPL = 0;
    localparam int BIT_MSG  = 1;

    typedef enum logic {
        EV_IDLE = 1'b0,
        EV_EVAL = 1'b1
    } eval_state_e;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_unit_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adapter_rst,
    input  logic             cmpl_evt,
    input  logic             msg_evt,
    input  logic             clr_wr,
    input  logic [REG_W-1:0] clr_data,
    output logic [REG_W-1:0] status_q
);
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] status_d;

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (i == BIT_CMPL) begin : g_cmpl
            assign set_vec[i] = cmpl_evt;
        end else if (i == BIT_MSG) begin : g_msg
            assign set_vec[i] = msg_evt;
        end else begin : g_none
            assign set_vec[i] = 1'b0;
        end
    end

    always_comb begin
        clr_vec  = clr_wr ? clr_data : '0;
        // a set in the same cycle overrides the clear
        status_d = adapter_rst ? '0 : ((status_q & ~clr_vec) | set_vec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] mask_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  mask_q <= '0;
        else if (wr) mask_q <= wdata;
    end
endmodule

// File: rtl/irq_notify_fsm.sv
module irq_notify_fsm
    import irq_unit_pkg::*;
#(
    parameter int PEND_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adapter_rst,
    input  logic              update,
    input  logic              ack_wr,
    input  logic [PEND_W-1:0] pend_cnt,
    input  logic              msg_mode,
    input  logic              cond,
    output logic              irq_level,
    output logic              irq_pulse,
    output logic              retry_req
);
    eval_state_e state_q;
    eval_state_e state_d;
    logic        retry_q;

    always_comb begin
        unique case (state_q)
            EV_IDLE: state_d = update ? EV_EVAL : EV_IDLE;
            EV_EVAL: state_d = update ? EV_EVAL : EV_IDLE;
        endcase
        if (adapter_rst) state_d = EV_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EV_IDLE;
            retry_q <= 1'b0;
        end else begin
            state_q <= state_d;
            retry_q <= !adapter_rst && ack_wr && (pend_cnt != '0);
        end
    end

    always_comb begin
        irq_level = cond && !msg_mode;
        irq_pulse = (state_q == EV_EVAL) && cond && msg_mode;
        retry_req = retry_q;
    end
endmodule

// File: rtl/irq_unit.sv
module irq_unit #(
    parameter int REG_W  = 8,
    parameter int PEND_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adapter_rst,
    input  logic              cmpl_evt,
    input  logic              msg_evt,
    input  logic              stat_wr,
    input  logic [REG_W-1:0]  stat_wdata,
    input  logic              mask_wr,
    input  logic [REG_W-1:0]  mask_wdata,
    input  logic              msg_mode,
    input  logic [PEND_W-1:0] cmpl_pending,
    output logic              irq_level,
    output logic              irq_pulse,
    output logic              retry_req
);
    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] mask_q;
    logic             update;
    logic             cond;

    assign update = cmpl_evt || msg_evt || stat_wr || mask_wr;
    assign cond   = |(mask_q & status_q);

    irq_status_reg #(.REG_W(REG_W)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .adapter_rst (adapter_rst),
        .cmpl_evt    (cmpl_evt),
        .msg_evt     (msg_evt),
        .clr_wr      (stat_wr),
        .clr_data    (stat_wdata),
        .status_q    (status_q)
    );

    irq_mask_reg #(.REG_W(REG_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (mask_wr),
        .wdata  (mask_wdata),
        .mask_q (mask_q)
    );

    irq_notify_fsm #(.PEND_W(PEND_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .adapter_rst (adapter_rst),
        .update      (update),
        .ack_wr      (stat_wr),
        .pend_cnt    (cmpl_pending),
        .msg_mode    (msg_mode),
        .cond        (cond),
        .irq_level   (irq_level),
        .irq_pulse   (irq_pulse),
        .retry_req   (retry_req)
    );
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk
    import irq_unit_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int PEND_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adapter_rst,
    input logic              cmpl_evt,
    input logic              stat_wr,
    input logic              mask_wr,
    input logic [REG_W-1:0]  mask_wdata,
    input logic              msg_mode,
    input logic [PEND_W-1:0] cmpl_pending,
    input logic [REG_W-1:0]  status_q,
    input logic [REG_W-1:0]  mask_q,
    input logic              irq_level,
    input logic              irq_pulse,
    input logic              retry_req
);
    // R9
    evt_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_evt && !adapter_rst |=> status_q[BIT_CMPL]);
    // R8
    status_wiped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adapter_rst |=> status_q == '0);
    // R8
    mask_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adapter_rst && !mask_wr |=> $stable(mask_q));
    // R3
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> mask_q == $past(mask_wdata));
    // R10
    no_pulse_in_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_mode |-> !irq_pulse);
    // R5
    line_quiet_in_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_mode |-> !irq_level);
    // R6
    pulse_needs_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (mask_q & status_q) != '0);
    // R7
    retry_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr && cmpl_pending != '0 && !adapter_rst |=> retry_req);
    // R7
    retry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |-> $past(stat_wr));
endmodule

bind irq_unit irq_unit_chk #(.REG_W(REG_W), .PEND_W(PEND_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .adapter_rst  (adapter_rst),
    .cmpl_evt     (cmpl_evt),
    .stat_wr      (stat_wr),
    .mask_wr      (mask_wr),
    .mask_wdata   (mask_wdata),
    .msg_mode     (msg_mode),
    .cmpl_pending (cmpl_pending),
    .status_q     (status_q),
    .mask_q       (mask_q),
    .irq_level    (irq_level),
    .irq_pulse    (irq_pulse),
    .retry_req    (retry_req)
);

// File: tb/irq_unit_bench.sv
`timescale 1ns/1ps
module irq_unit_bench;
    localparam int REG_W  = 8;
    localparam int PEND_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              adapter_rst = 1'b0;
    logic              cmpl_evt = 1'b0;
    logic              msg_evt = 1'b0;
    logic              stat_wr = 1'b0;
    logic [REG_W-1:0]  stat_wdata = '0;
    logic              mask_wr = 1'b0;
    logic [REG_W-1:0]  mask_wdata = '0;
    logic              msg_mode = 1'b0;
    logic [PEND_W-1:0] cmpl_pending = '0;
    logic              irq_level;
    logic              irq_pulse;
    logic              retry_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [REG_W-1:0] m_stat = '0;
    logic [REG_W-1:0] m_mask = '0;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    irq_unit #(.REG_W(REG_W), .PEND_W(PEND_W)) u_irq_unit (
        .clk(clk), .rst_n(rst_n), .adapter_rst(adapter_rst),
        .cmpl_evt(cmpl_evt), .msg_evt(msg_evt),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .msg_mode(msg_mode), .cmpl_pending(cmpl_pending),
        .irq_level(irq_level), .irq_pulse(irq_pulse), .retry_req(retry_req)
    );

    task automatic check3(input logic [2:0] act, input logic [2:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {level,pulse,retry} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and queues the expected outputs
    task automatic drive(input logic ce, input logic me, input logic sw,
                         input logic [REG_W-1:0] swd, input logic mw,
                         input logic [REG_W-1:0] mwd, input logic mode,
                         input logic [PEND_W-1:0] pend, input logic ar,
                         input string tag);
        logic upd;
        logic cnd;
        logic [REG_W-1:0] setv;
        @(negedge clk);
        cmpl_evt = ce; msg_evt = me; stat_wr = sw; stat_wdata = swd;
        mask_wr = mw; mask_wdata = mwd; msg_mode = mode;
        cmpl_pending = pend; adapter_rst = ar;
        setv = '0;
        setv[0] = ce;
        setv[1] = me;
        m_stat = ar ? '0 : ((m_stat & ~(sw ? swd : '0)) | setv);
        if (mw) m_mask = mwd;
        upd = (ce || me || sw || mw) && !ar;
        cnd = |(m_stat & m_mask);
        exp_q.push_back({cnd && !mode, upd && cnd && mode, sw && (pend != '0) && !ar});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input logic mode, input string tag);
        drive(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, mode, '0, 1'b0, tag);
    endtask

    // monitor: compares after each edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [2:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check3({irq_level, irq_pulse, retry_req}, e, t);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check3({irq_level, irq_pulse, retry_req}, 3'b000, "R8 reset state");
        rst_n = 1'b1;
        // level mode
        drive(0,0,0,'0,1,8'h03,0,'0,0, "R3 mask load");
        drive(1,0,0,'0,0,'0,0,'0,0, "R1 R4 completion event");
        drive(0,0,1,8'h01,0,'0,0,8'd0,0, "R2 R7 ack without pending");
        drive(0,1,0,'0,0,'0,0,'0,0, "R1 message event");
        drive(0,0,0,'0,1,8'h01,0,'0,0, "R3 mask hides message bit");
        drive(0,0,0,'0,1,8'h02,0,'0,0, "R3 mask exposes message bit");
        drive(0,0,1,8'h02,0,'0,0,8'd3,0, "R7 ack with pending");
        idle(0, "R7 retry one cycle");
        drive(0,0,0,'0,1,8'h03,0,'0,0, "R3 mask both");
        drive(1,0,1,8'h01,0,'0,0,'0,0, "R9 event beats clear");
        drive(1,1,1,8'hFF,0,'0,0,8'd1,0, "R9 R7 both events beat full clear");
        drive(0,0,0,'0,0,'0,0,'0,1, "R8 adapter reset clears status");
        drive(1,0,0,'0,0,'0,0,'0,0, "R8 mask survived adapter reset");
        drive(0,0,1,8'h01,0,'0,0,'0,0, "R2 ack completion");
        // message mode
        idle(1, "R5 mode switch no pulse");
        drive(0,1,0,'0,0,'0,1,'0,0, "R5 pulse on message event");
        idle(1, "R5 pulse one clock wide");
        drive(0,0,1,8'h03,0,'0,1,8'd2,0, "R6 R7 ack leaves nothing");
        drive(0,0,0,'0,1,8'h00,1,'0,0, "R6 mask zero");
        drive(1,0,0,'0,0,'0,1,'0,0, "R6 event while masked");
        drive(0,0,0,'0,1,8'h01,1,'0,0, "R5 mask write re-evaluates");
        drive(0,0,0,'0,1,8'h01,1,'0,0, "R5 repeated re-evaluation");
        drive(0,0,0,'0,1,8'h01,0,'0,0, "R10 R4 level mode no pulse");
        idle(0, "R4 level holds");
        idle(0, "R4 final");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule